// File: doc/BRIEF.md
# Bit-Instruction Memory Microcycle Sequencer

This block orders the bus microcycles of a read-modify-write bit instruction (set or toggle a single bit) for each destination addressing mode. A start strobe captures the addressing mode, the address register number, the access size and whether the bit number arrives as an immediate extension word. The block then issues one microcycle code per accepted clock: internal idle, data read, program fetch or data write. A ready input lets the surrounding bus logic stall it at any point.

For the post-increment and pre-decrement modes the block also tells the register file by how much, and in which direction, the address register must move. A single write strobe carries this, together with the step size and a decrement flag. A byte access through register 7, the stack pointer, moves it by two so that it stays word aligned. A one-cycle done pulse closes every instruction, and the sequencer is then free to accept the next start.

Top module: `bitop_bus_seq`

## Requirements
- R1: Microcycle codes are 0 idle, 1 data read, 2 program fetch, 3 data write. Mode is encoded as 0 data register, 1 indirect, 2 post-increment, 3 pre-decrement, 4 displacement, 5 indexed, 6 short absolute, 7 long absolute. For mode 0 the sequence is fetch, idle.
- R2: Modes 1 and 2 issue read, fetch, write.
- R3: Mode 3 issues idle, read, fetch, write. The step strobe is raised with the decrement flag set (step_dec=1) during its leading idle microcycle, and only in the cycle that this microcycle is accepted with ready high.
- R4: For mode 2 the step strobe, with step_dec=0, is raised in the done cycle, after the write has been issued.
- R5: Modes 4 and 6 issue fetch, read, fetch, write. Mode 5 issues idle, fetch, read, fetch, write.
- R6: Mode 7 issues fetch, fetch, read, fetch, write.
- R7: When the immediate flag is captured high, one extra program fetch precedes the mode's sequence.
- R8: Step amount, with size 0 byte, 1 word and 2 long: 4 for long, 2 for word, 1 for byte, except that a byte access through register 7 steps by 2.
- R9: While ready is low the current microcycle code stays on the output and the sequence does not advance. A microcycle is accepted on a clock edge where mc_valid and ready are both high.
- R10: Done is high for exactly one cycle, the cycle after the last microcycle is accepted. mc_valid is low in that cycle, and the block is idle in the next one.
- R11: A start strobe raised while a sequence runs, or in the done cycle, is ignored.
- R12: After reset mc_valid, done and step_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| ea_mode | input | 3 | Destination addressing mode |
| ea_reg | input | 3 | Address register number |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 long |
| imm_bitno | input | 1 | Bit number taken from an extension word |
| ready | input | 1 | Current microcycle may complete |
| mc_valid | output | 1 | A microcycle code is presented |
| mc_code | output | 2 | Microcycle code |
| step_we | output | 1 | Address register step strobe |
| step_amt | output | 3 | Step amount |
| step_dec | output | 1 | Step direction is decrement |
| done | output | 1 | Sequence finished |

## Verification
In post-increment mode, two events share one cycle: the address-step strobe and the done pulse. The bench checks that both appear together, with the increment direction and the size-dependent amount. In pre-decrement mode the strobe must instead fall on the leading idle microcycle, only in its accepted cycle, and never with done. Random ready stalls are placed on that first microcycle to show that the strobe waits for acceptance. Start pulses are placed in the done cycle and in the middle of a sequence to confirm they are ignored.

// File: rtl/bitop_bus_seq.sv
module bitop_bus_seq #(
  parameter int POS_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] ea_mode,
  input  logic [2:0] ea_reg,
  input  logic [1:0] acc_size,
  input  logic       imm_bitno,
  input  logic       ready,
  output logic       mc_valid,
  output logic [1:0] mc_code,
  output logic       step_we,
  output logic [2:0] step_amt,
  output logic       step_dec,
  output logic       done
);
  localparam logic [1:0] C_IDLE = 2'd0, C_RD = 2'd1, C_FETCH = 2'd2, C_WR = 2'd3;
  localparam logic [2:0] M_DREG = 3'd0, M_IND = 3'd1, M_PINC = 3'd2, M_PDEC = 3'd3,
                         M_D16 = 3'd4, M_IDX = 3'd5, M_ABSW = 3'd6, M_ABSL = 3'd7;

  logic             busy, fin;
  logic [2:0]       mode_q, reg_q;
  logic [1:0]       size_q;
  logic             imm_q;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] body_pos;
  logic [POS_W-1:0] body_len;
  logic [1:0]       body_code;
  logic             last;

  assign body_pos = pos - POS_W'(imm_q);

  always_comb begin
    case (mode_q)
      M_DREG:        body_len = POS_W'(2);
      M_IND, M_PINC: body_len = POS_W'(3);
      M_PDEC, M_D16,
      M_ABSW:        body_len = POS_W'(4);
      default:       body_len = POS_W'(5);
    endcase
  end

  always_comb begin
    body_code = C_IDLE;
    case (mode_q)
      M_DREG: body_code = (body_pos == 0) ? C_FETCH : C_IDLE;
      M_IND, M_PINC:
        case (body_pos)
          POS_W'(0): body_code = C_RD;
          POS_W'(1): body_code = C_FETCH;
          default:   body_code = C_WR;
        endcase
      M_PDEC:
        case (body_pos)
          POS_W'(0): body_code = C_IDLE;
          POS_W'(1): body_code = C_RD;
          POS_W'(2): body_code = C_FETCH;
          default:   body_code = C_WR;
        endcase
      M_D16, M_ABSW:
        case (body_pos)
          POS_W'(1): body_code = C_RD;
          POS_W'(3): body_code = C_WR;
          default:   body_code = C_FETCH;
        endcase
      M_IDX:
        case (body_pos)
          POS_W'(0): body_code = C_IDLE;
          POS_W'(2): body_code = C_RD;
          POS_W'(4): body_code = C_WR;
          default:   body_code = C_FETCH;
        endcase
      default:
        case (body_pos)
          POS_W'(2): body_code = C_RD;
          POS_W'(4): body_code = C_WR;
          default:   body_code = C_FETCH;
        endcase
    endcase
  end

  assign last     = (pos == body_len - POS_W'(1) + POS_W'(imm_q));
  assign mc_valid = busy;
  assign mc_code  = !busy ? C_IDLE : (imm_q && pos == 0) ? C_FETCH : body_code;
  assign done     = fin;

  assign step_dec = (mode_q == M_PDEC);
  assign step_amt = (size_q[1])              ? 3'd4 :
                    (size_q[0])              ? 3'd2 :
                    (reg_q == 3'd7)          ? 3'd2 : 3'd1;
  assign step_we  = (fin && mode_q == M_PINC) ||
                    (busy && ready && mode_q == M_PDEC && pos == POS_W'(imm_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      fin    <= 1'b0;
      pos    <= '0;
      mode_q <= M_DREG;
      reg_q  <= 3'd0;
      size_q <= 2'd0;
      imm_q  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (busy) begin
        if (ready) begin
          if (last) begin
            busy <= 1'b0;
            fin  <= 1'b1;
            pos  <= '0;
          end else begin
            pos <= pos + POS_W'(1);
          end
        end
      end else if (!fin && start) begin
        busy   <= 1'b1;
        pos    <= '0;
        mode_q <= ea_mode;
        reg_q  <= ea_reg;
        size_q <= acc_size;
        imm_q  <= imm_bitno;
      end
    end
  end
endmodule

// File: rtl/bitop_bus_seq_chk.sv
module bitop_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       mc_valid,
  input logic [1:0] mc_code,
  input logic       step_we,
  input logic [2:0] step_amt,
  input logic       done
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mc_valid); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !mc_valid); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && !ready) |=> (mc_valid && $stable(mc_code))); // R9
  AST_STEP_AMT: assert property (@(posedge clk) disable iff (!rst_n)
    step_we |-> (step_amt == 3'd1 || step_amt == 3'd2 || step_amt == 3'd4)); // R8
  AST_STEP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    step_we |-> (done || (mc_valid && ready && mc_code == 2'd0))); // R3
endmodule

bind bitop_bus_seq bitop_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .mc_valid(mc_valid), .mc_code(mc_code),
  .step_we(step_we), .step_amt(step_amt), .done(done)
);

// File: tb/bitop_bus_seq_test.sv
module bitop_bus_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] ea_mode = 3'd0, ea_reg = 3'd0;
  logic [1:0] acc_size = 2'd0;
  logic imm_bitno = 1'b0;
  logic ready = 1'b0;
  logic mc_valid, step_we, step_dec, done;
  logic [1:0] mc_code;
  logic [2:0] step_amt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  bitop_bus_seq uut (.*);

  function automatic int exp_len(input logic [2:0] m, input logic imm);
    int b;
    case (m)
      3'd0: b = 2;
      3'd1, 3'd2: b = 3;
      3'd3, 3'd4, 3'd6: b = 4;
      default: b = 5;
    endcase
    return b + int'(imm);
  endfunction

  function automatic logic [1:0] exp_code(input logic [2:0] m, input logic imm, input int k);
    int j;
    if (imm && k == 0) return 2'd2;
    j = k - int'(imm);
    case (m)
      3'd0: return (j == 0) ? 2'd2 : 2'd0;
      3'd1, 3'd2: return (j == 0) ? 2'd1 : (j == 1) ? 2'd2 : 2'd3;
      3'd3: return (j == 0) ? 2'd0 : (j == 1) ? 2'd1 : (j == 2) ? 2'd2 : 2'd3;
      3'd4, 3'd6: return (j == 1) ? 2'd1 : (j == 3) ? 2'd3 : 2'd2;
      3'd5: return (j == 0) ? 2'd0 : (j == 2) ? 2'd1 : (j == 4) ? 2'd3 : 2'd2;
      default: return (j == 2) ? 2'd1 : (j == 4) ? 2'd3 : 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] exp_amt(input logic [1:0] s, input logic [2:0] r);
    if (s[1]) return 3'd4;
    if (s[0]) return 3'd2;
    return (r == 3'd7) ? 3'd2 : 3'd1;
  endfunction

  function automatic string mreq(input logic [2:0] m, input logic imm);
    if (imm) return "R7";
    case (m)
      3'd0: return "R1";
      3'd1, 3'd2: return "R2";
      3'd3: return "R3";
      3'd4, 3'd5, 3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                        input logic imm, input int rdy_pct, input bit poke);
    int len, k;
    bit rdy;
    len = exp_len(m, imm);
    @(negedge clk);
    start = 1'b1; ea_mode = m; ea_reg = r; acc_size = s; imm_bitno = imm;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (k < len) begin
      rdy = ($urandom_range(99) < rdy_pct);
      ready = rdy;
      if (poke && ($urandom_range(3) == 0)) begin
        start = 1'b1; ea_mode = ~m; ea_reg = ~r; imm_bitno = ~imm;
      end else start = 1'b0;
      #1;
      chk(mc_valid === 1'b1, "R11", int'(mc_valid), 1);
      chk(mc_code === exp_code(m, imm, k), rdy ? mreq(m, imm) : "R9",
          int'(mc_code), int'(exp_code(m, imm, k)));
      chk(done === 1'b0, "R10", int'(done), 0);
      if (m == 3'd3 && k == int'(imm) && rdy) begin
        chk(step_we === 1'b1 && step_dec === 1'b1, "R3", int'(step_we), 1);
        chk(step_amt === exp_amt(s, r), "R8", int'(step_amt), int'(exp_amt(s, r)));
      end else begin
        chk(step_we === 1'b0, (m == 3'd3) ? "R3" : "R4", int'(step_we), 0);
      end
      @(negedge clk);
      if (rdy) k++;
    end
    ready = $urandom_range(1);
    start = poke;
    ea_mode = 3'd1; imm_bitno = 1'b0;
    #1;
    chk(done === 1'b1, "R10", int'(done), 1);
    chk(mc_valid === 1'b0, "R10", int'(mc_valid), 0);
    if (m == 3'd2) begin
      chk(step_we === 1'b1 && step_dec === 1'b0, "R4", int'(step_we), 1);
      chk(step_amt === exp_amt(s, r), "R8", int'(step_amt), int'(exp_amt(s, r)));
    end else begin
      chk(step_we === 1'b0, "R4", int'(step_we), 0);
    end
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(done === 1'b0, "R10", int'(done), 0);
    chk(mc_valid === 1'b0, poke ? "R11" : "R10", int'(mc_valid), 0);
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(mc_valid === 1'b0, "R12", int'(mc_valid), 0);
    chk(done === 1'b0, "R12", int'(done), 0);
    chk(step_we === 1'b0, "R12", int'(step_we), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < 8; m++) begin
      run_op(3'(m), 3'd2, 2'd0, 1'b0, 100, 1'b0);
      run_op(3'(m), 3'd4, 2'd0, 1'b1, 100, 1'b0);
    end
    run_op(3'd2, 3'd7, 2'd0, 1'b0, 100, 1'b0);
    run_op(3'd3, 3'd7, 2'd0, 1'b1, 100, 1'b0);
    run_op(3'd2, 3'd3, 2'd1, 1'b0, 100, 1'b0);
    run_op(3'd3, 3'd7, 2'd2, 1'b0, 30, 1'b0);
    run_op(3'd2, 3'd7, 2'd2, 1'b1, 30, 1'b1);
    run_op(3'd7, 3'd0, 2'd0, 1'b1, 20, 1'b1);
    for (int i = 0; i < 400; i++) begin
      run_op(3'($urandom_range(7)), 3'($urandom_range(7)), 2'($urandom_range(2)),
             1'($urandom_range(1)), 40 + $urandom_range(60), 1'($urandom_range(1)));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule